// File: doc/BRIEF.md
# Start-Bit Oversampling Majority Receiver

This block receives serial characters from the data output of a power-line modem on links that have no zero crossing to synchronise to, such as DC lines. The line rests high. A character starts with a falling edge. The receiver checks that the line is still low half a bit later, and then reads each bit on a sample tick that runs at sixteen times the bit rate. Each bit is settled by a majority vote over five samples taken near the middle of the bit period.

Each character carries a start bit, a frame bit, eight data bits, a parity bit and a stop bit. When the stop bit has been read, the block gives a one-cycle strobe. Alongside the strobe it presents the frame bit, the data byte, a parity-check result and a stop-bit check. Whether the frame bit is counted in the parity depends on its value. The sample tick is divided down from the clock by a parameter, so the sender must use the same bit rate.

Top module: `plm_start_rx`

## Requirements
- R1: After reset, `byte_valid`, `frame_bit`, `data_out`, `parity_error` and `framing_error` are all 0. While `rx_in` stays high, no strobe is raised.
- R2: A falling edge on `rx_in` starts a character only if the line is sampled low again at sample slot 8 of the start bit (half a bit period). A low pulse shorter than that is dropped, and the receiver returns to waiting for an edge.
- R3: A sample tick occurs every `SAMPLE_DIV` clocks, and one bit lasts 16 ticks. The strobe for a character comes 11 bit periods plus 10 to 11 tick periods after the falling start edge, plus a small synchroniser delay.
- R4: Each bit is set by the majority of its samples in slots 6, 7, 8, 9 and 10. A wrong level that covers one sample slot does not change the received value.
- R5: The bits follow the start bit in this order: frame bit, data bit 0 (LSB) through data bit 7, parity bit, stop bit. `frame_bit` and `data_out` carry the received values.
- R6: Parity is even. When the frame bit equals `FRAME_MARK` (default 1, meaning a frame/start byte), the check covers the frame bit, the eight data bits and the parity bit. Otherwise it covers only the data bits and the parity bit. `parity_error` is 1 when the covered bits XOR to 1.
- R7: A stop bit that is received low sets `framing_error` to 1, and the character is still delivered with its fields.
- R8: `byte_valid` is a single-cycle pulse, once per accepted character. The output fields hold their values until the next pulse.
- R9: After the stop bit has been decided, the receiver waits for a new edge at once. A character that follows directly after a stop bit, with no idle gap, is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial data from the modem, high when idle |
| byte_valid | output | 1 | One-cycle strobe for a received character |
| frame_bit | output | 1 | Received frame bit |
| data_out | output | 8 | Received data byte |
| parity_error | output | 1 | Even-parity check failed |
| framing_error | output | 1 | Stop bit was received low |

## Verification
A parity failure and a framing failure can be reported in the same strobe cycle, since both are settled as the stop bit ends. The bench sends characters that carry a wrong parity bit and a low stop bit at once, both as directed cases and at random. It expects both flags set together with the correct data and frame bit. It also sends cases where only one of the two is wrong, to show that each flag responds to its own cause alone.

// File: rtl/plm_start_rx.sv
module plm_start_rx #(
  parameter int SAMPLE_DIV = 4,
  parameter int VOTE_FIRST = 6,
  parameter int VOTES      = 5,
  parameter bit FRAME_MARK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  output logic       byte_valid,
  output logic       frame_bit,
  output logic [7:0] data_out,
  output logic       parity_error,
  output logic       framing_error
);
  localparam int DIV_W      = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int VOTE_LAST  = VOTE_FIRST + VOTES - 1;
  localparam int VOTE_W     = $clog2(VOTES + 1);
  localparam int CHECK_SLOT = 8;
  localparam int STOP_IDX   = 11;
  localparam int PAR_IDX    = 10;

  logic [1:0]       rx_sync;
  logic             rx_s;
  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic             busy;
  logic [3:0]       slot, slot_now;
  logic [3:0]       bit_idx, bit_now;
  logic [VOTE_W-1:0] votes, vote_sum;
  logic             maj;
  logic             fb_r, par_r;
  logic [7:0]       sh_r;
  logic             par_calc;

  assign rx_s     = rx_sync[1];
  assign tick     = (div_cnt == DIV_W'(SAMPLE_DIV - 1));
  assign slot_now = slot + 4'd1;
  assign bit_now  = (slot == 4'd15) ? bit_idx + 4'd1 : bit_idx;
  assign vote_sum = votes + VOTE_W'(rx_s);
  assign maj      = (vote_sum > VOTE_W'(VOTES / 2));
  assign par_calc = (^sh_r) ^ par_r ^ ((fb_r == FRAME_MARK) ? fb_r : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      div_cnt <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rx_in};
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      slot          <= '0;
      bit_idx       <= '0;
      votes         <= '0;
      fb_r          <= 1'b0;
      par_r         <= 1'b0;
      sh_r          <= '0;
      byte_valid    <= 1'b0;
      frame_bit     <= 1'b0;
      data_out      <= '0;
      parity_error  <= 1'b0;
      framing_error <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (tick) begin
        if (!busy) begin
          if (!rx_s) begin
            busy    <= 1'b1;
            slot    <= '0;
            bit_idx <= '0;
            votes   <= '0;
          end
        end else begin
          slot    <= slot_now;
          bit_idx <= bit_now;
          if (bit_now == 4'd0 && slot_now == 4'(CHECK_SLOT) && rx_s)
            busy <= 1'b0;
          if (slot_now >= 4'(VOTE_FIRST) && slot_now < 4'(VOTE_LAST))
            votes <= vote_sum;
          if (slot_now == 4'(VOTE_LAST)) begin
            votes <= '0;
            if (bit_now == 4'd1)
              fb_r <= maj;
            else if (bit_now >= 4'd2 && bit_now <= 4'd9)
              sh_r <= {maj, sh_r[7:1]};
            else if (bit_now == 4'(PAR_IDX))
              par_r <= maj;
            else if (bit_now == 4'(STOP_IDX)) begin
              busy          <= 1'b0;
              byte_valid    <= 1'b1;
              frame_bit     <= fb_r;
              data_out      <= sh_r;
              parity_error  <= par_calc;
              framing_error <= ~maj;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/plm_start_rx_chk.sv
module plm_start_rx_chk #(
  parameter int CHECK_SLOT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rx_s,
  input logic       busy,
  input logic [3:0] slot,
  input logic [3:0] bit_idx,
  input logic       byte_valid
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tick && rx_s) |=> !busy); // R1
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && bit_idx == 4'd0 && slot == 4'(CHECK_SLOT - 1) && rx_s) |=> !busy); // R2
  AST_VALID_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (!busy && $past(bit_idx) == 4'd11)); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(slot)); // R3
endmodule

bind plm_start_rx plm_start_rx_chk #(.CHECK_SLOT(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .busy(busy),
  .slot(slot), .bit_idx(bit_idx), .byte_valid(byte_valid)
);

// File: tb/plm_start_rx_tb.sv
module plm_start_rx_tb;
  localparam int DIV = 4;
  localparam int BITCLK = 16 * DIV;
  localparam bit MARK = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic byte_valid, frame_bit, parity_error, framing_error;
  logic [7:0] data_out;

  int errs = 0, checks = 0;
  int cyc = 0, t_edge = 0, t_valid = 0, got_n = 0, pulse_len = 0, max_pulse = 0;
  logic g_fb, g_pe, g_fe;
  logic [7:0] g_d;

  plm_start_rx #(.SAMPLE_DIV(DIV), .FRAME_MARK(MARK)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .byte_valid(byte_valid),
    .frame_bit(frame_bit), .data_out(data_out),
    .parity_error(parity_error), .framing_error(framing_error));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (byte_valid) begin
      got_n   = got_n + 1;
      t_valid = cyc;
      g_fb = frame_bit; g_d = data_out; g_pe = parity_error; g_fe = framing_error;
      pulse_len = pulse_len + 1;
      if (pulse_len > max_pulse) max_pulse = pulse_len;
    end else pulse_len = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_perr(input bit fb, input logic [7:0] d, input bit p);
    return p ^ (^d) ^ ((fb == MARK) ? fb : 1'b0);
  endfunction

  task automatic send(input bit fb, input logic [7:0] d, input bit p, input bit stop,
                      input int spike_bit);
    logic [11:0] bits;
    bits = {stop, p, d, fb, 1'b0};
    @(negedge clk);
    t_edge = cyc;
    for (int b = 0; b < 12; b++) begin
      for (int c = 0; c < BITCLK; c++) begin
        rx = bits[b] ^ ((b == spike_bit) && c >= 32 && c < 32 + DIV);
        if (!(b == 11 && c == BITCLK - 1)) @(negedge clk);
      end
    end
  endtask

  task automatic frame_check(input bit fb, input logic [7:0] d, input bit p, input bit stop,
                             input int spike_bit, input bit timing);
    int n0;
    n0 = got_n;
    send(fb, d, p, stop, spike_bit);
    @(negedge clk);
    rx = 1'b1;
    chk(got_n == n0 + 1, "R8 strobe count", got_n - n0, 1);
    chk(g_fb == fb && g_d == d, "R5 fields", {g_fb, g_d}, {fb, d});
    chk(g_pe == exp_perr(fb, d, p), "R6 parity_error", g_pe, exp_perr(fb, d, p));
    chk(g_fe == !stop, "R7 framing_error", g_fe, !stop);
    if (spike_bit >= 0) chk(g_d == d && g_fb == fb, "R4 spike voted out", g_d, d);
    if (timing)
      chk((t_valid - t_edge) >= 11 * BITCLK + 10 * DIV + 1 &&
          (t_valid - t_edge) <= 11 * BITCLK + 11 * DIV + 2,
          "R3 strobe latency", t_valid - t_edge, 11 * BITCLK + 10 * DIV);
    if (!stop) repeat (5 * BITCLK) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(byte_valid == 0 && frame_bit == 0 && data_out == 0 && parity_error == 0 &&
        framing_error == 0, "R1 reset state", {byte_valid, data_out}, 0);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    chk(got_n == 0, "R1 idle no strobe", got_n, 0);

    n0 = got_n;
    rx = 1'b0; repeat (3 * DIV) @(negedge clk); rx = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(got_n == n0, "R2 short start rejected", got_n - n0, 0);
    n0 = got_n;
    rx = 1'b0; repeat (6 * DIV) @(negedge clk); rx = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(got_n == n0, "R2 sub-half-bit start rejected", got_n - n0, 0);

    frame_check(1'b1, 8'hA5, 1'b0, 1'b1, -1, 1'b1);
    frame_check(1'b0, 8'h3C, 1'b0, 1'b1, -1, 1'b1);
    frame_check(1'b1, 8'h3C, 1'b0, 1'b1, -1, 1'b0);
    frame_check(1'b0, 8'h01, 1'b0, 1'b1, -1, 1'b0);
    frame_check(1'b0, 8'h80, 1'b1, 1'b0, -1, 1'b0);
    frame_check(1'b1, 8'hFF, 1'b1, 1'b0, -1, 1'b0);
    frame_check(1'b0, 8'h55, 1'b1, 1'b0, 4, 1'b0);
    frame_check(1'b1, 8'h0F, 1'b0, 1'b1, 1, 1'b0);
    frame_check(1'b0, 8'hC3, 1'b0, 1'b1, 10, 1'b0);

    n0 = got_n;
    send(1'b1, 8'h12, 1'b1, 1'b1, -1);
    send(1'b0, 8'h34, 1'b1, 1'b1, -1);
    @(negedge clk); rx = 1'b1;
    chk(got_n == n0 + 2 && g_d == 8'h34, "R9 back-to-back", g_d, 8'h34);

    for (int i = 0; i < 60; i++) begin
      bit fb, p, stop;
      logic [7:0] d;
      int sp;
      fb = 1'($urandom);
      d = 8'($urandom);
      p = 1'($urandom);
      stop = ($urandom % 6) != 0;
      sp = ($urandom % 3 == 0) ? 1 + int'($urandom % 10) : -1;
      frame_check(fb, d, p, stop, sp, 1'b1);
      repeat ($urandom % 100) @(negedge clk);
    end
    chk(max_pulse == 1, "R8 single-cycle strobe", max_pulse, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule